// File: doc/BRIEF.md
# Output Voltage Slew Sequencer

This block moves a 6-bit converter voltage code from its present value towards a target, one code step at a time. The step rate can be programmed. The target comes from one of two programmed target registers, and a select pin chooses which one. The present code goes straight to the converter's reference DAC. The block also gives the same code as a millivolt value.

A change starts in either of two ways: a register-write strobe, or any level change on the select pin. A single busy flag rises when a change starts and falls on the clock edge where the code reaches the target. That flag serves as both the self-clearing "go" bit and the read-only "voltage change in progress" status. The flag tracks the code and not the analog output.

The voltage map is not uniform:

- Codes 0 to 31 rise in 25 mV steps from 800 mV.
- Codes 32 to 60 rise in 50 mV steps from 1600 mV.
- Codes 61, 62 and 63 are 3100, 3200 and 3300 mV.

Each step waits in proportion to its voltage size, so a 50 mV step takes twice as long as a 25 mV step. The slowest setting waits longest. Setting 7 jumps to the target at once. Outside reset, the two target registers are expected to reset to code 16 (1.2 V, low) and code 8 (1.0 V, high), and the rate setting to 6.

Top module: `vslew_seq`

## Requirements
- R1: During and right after reset, `code` equals `RESET_CODE` (default 16), `level_mv` reads 1200 and `busy` is 0.
- R2: The target is `tgt_lo` while `sel` is 0 and `tgt_hi` while `sel` is 1.
- R3: A cycle with `wr_stb` high and a target different from `code` makes `busy` read 1 after that edge. A strobe whose target equals `code` leaves `busy` at 0 and `code` unchanged.
- R4: A level change on `sel` starts a change exactly as a strobe does, with no strobe needed.
- R5: For `rate` 0 to 6, `code` changes by exactly one per step, upward or downward toward the target.
- R6: A step needs `u * BASE_TICKS * 2^(6-rate)` cycles with `tick` high. The step size `u` depends on the lower code `k` of the step: u=1 for k up to 31, u=2 for k from 32 to 59, and u=4 for k of 60 or more. No step happens without `tick`.
- R7: With `rate` = 7, `code` equals the target on the first edge after `busy` rises, and `busy` falls on that same edge.
- R8: `busy` falls on the edge where `code` reaches the target, and `code` then holds.
- R9: While `busy` is 1, a target change needs no strobe. The code turns toward the new target from its present value without jumping.
- R10: While `busy` is 0, changes to `tgt_lo` or `tgt_hi` without a strobe or `sel` change leave `code` and `busy` unchanged.
- R11: `level_mv` follows the code map: 800+25c for c<32, 1600+50(c-32) for 32≤c≤60, and 3100+100(c-61) for c≥61.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tgt_lo | input | 6 | Target code used while sel is 0 |
| tgt_hi | input | 6 | Target code used while sel is 1 |
| sel | input | 1 | Target select pin; a level change starts a change |
| rate | input | 3 | Slew setting; 0 is slowest, 6 is fastest, 7 is immediate |
| wr_stb | input | 1 | Register-write strobe that starts a change |
| tick | input | 1 | Timebase tick that paces steps |
| code | output | 6 | Present voltage code to the reference DAC |
| level_mv | output | 12 | Present code in millivolts |
| busy | output | 1 | Change in progress (go / status bit) |

## Verification
A target redirect and a step firing can fall in the same cycle. With `tick` held high at the fastest paced rate, every busy cycle fires a step. The bench rewrites the target mid-ramp on exactly such a cycle, without a strobe. It then judges that the code turns back one code at a time, with no jump, and that `busy` falls after the expected number of cycles. A strobe arriving while a `sel` edge is pending is a second coincidence. It gives the same start, so the two are treated as one event.

// File: rtl/vslew_pkg.sv
package vslew_pkg;

    localparam int CODE_W = 6;
    localparam int RATE_W = 3;
    localparam int MV_W   = 12;
    localparam logic [RATE_W-1:0] RATE_JUMP    = 3'd7;
    localparam logic [RATE_W-1:0] RATE_FASTEST = 3'd6;

    typedef logic [CODE_W-1:0] vcode_t;
    typedef logic [RATE_W-1:0] vrate_t;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } vdir_t;

    // Size, in 25 mV units, of the step between codes k and k+1.
    function automatic logic [2:0] step_units(input vcode_t k);
        if (k <= vcode_t'(31))      return 3'd1;
        else if (k <= vcode_t'(59)) return 3'd2;
        else                        return 3'd4;
    endfunction

    function automatic logic [MV_W-1:0] code_to_mv(input vcode_t c);
        logic [MV_W-1:0] cw;
        cw = MV_W'(c);
        if (c < vcode_t'(32))       return MV_W'(800)  + MV_W'(25 * cw);
        else if (c < vcode_t'(61))  return MV_W'(1600) + MV_W'(50 * (cw - MV_W'(32)));
        else                        return MV_W'(3100) + MV_W'(100 * (cw - MV_W'(61)));
    endfunction

endpackage

// File: rtl/vslew_target.sv
module vslew_target
    import vslew_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  vcode_t tgt_lo,
    input  vcode_t tgt_hi,
    input  logic   sel,
    input  logic   wr_stb,
    output vcode_t tgt,
    output logic   start
);
    logic sel_q;

    always_ff @(posedge clk) begin
        if (rst) sel_q <= sel;
        else     sel_q <= sel;
    end

    assign tgt   = sel ? tgt_hi : tgt_lo;
    assign start = wr_stb || (sel != sel_q);
endmodule

// File: rtl/vslew_pacer.sv
module vslew_pacer
    import vslew_pkg::*;
#(
    parameter int BASE_TICKS = 1
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       run,
    input  logic       tick,
    input  vrate_t     rate,
    input  logic [2:0] units,
    output logic       fire
);
    localparam int MAX_NEED = 4 * BASE_TICKS * 64;
    localparam int CW       = $clog2(MAX_NEED + 1) + 1;

    logic [CW-1:0]     cnt;
    logic [CW-1:0]     need;
    logic [RATE_W-1:0] shamt;

    always_comb begin
        shamt = RATE_FASTEST - rate;
        need  = CW'(CW'(units) * CW'(BASE_TICKS)) << shamt;
        fire  = run && tick && (CW'(cnt + 1'b1) >= need);
    end

    always_ff @(posedge clk) begin
        if (rst || !run) cnt <= '0;
        else if (tick)   cnt <= fire ? '0 : CW'(cnt + 1'b1);
    end
endmodule

// File: rtl/vslew_seq.sv
module vslew_seq
    import vslew_pkg::*;
#(
    parameter int             BASE_TICKS = 1,
    parameter logic [5:0]     RESET_CODE = 6'd16
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [5:0]  tgt_lo,
    input  logic [5:0]  tgt_hi,
    input  logic        sel,
    input  logic [2:0]  rate,
    input  logic        wr_stb,
    input  logic        tick,
    output logic [5:0]  code,
    output logic [11:0] level_mv,
    output logic        busy
);
    vcode_t     code_q, code_n, tgt;
    logic       go_q, go_n, start, fire, moving;
    vdir_t      dir;
    vcode_t     low_end;
    logic [2:0] units;

    vslew_target u_target (
        .clk    (clk),
        .rst    (rst),
        .tgt_lo (tgt_lo),
        .tgt_hi (tgt_hi),
        .sel    (sel),
        .wr_stb (wr_stb),
        .tgt    (tgt),
        .start  (start)
    );

    always_comb begin
        moving  = go_q && (code_q != tgt);
        dir     = (tgt > code_q) ? DIR_UP : DIR_DOWN;
        low_end = (dir == DIR_UP) ? code_q : vcode_t'(code_q - 1'b1);
        units   = step_units(low_end);
    end

    vslew_pacer #(.BASE_TICKS(BASE_TICKS)) u_pacer (
        .clk   (clk),
        .rst   (rst),
        .run   (moving && (rate != RATE_JUMP)),
        .tick  (tick),
        .rate  (rate),
        .units (units),
        .fire  (fire)
    );

    always_comb begin
        code_n = code_q;
        if (moving) begin
            if (rate == RATE_JUMP)  code_n = tgt;
            else if (fire)          code_n = (dir == DIR_UP) ? vcode_t'(code_q + 1'b1)
                                                             : vcode_t'(code_q - 1'b1);
        end
        go_n = (start || go_q) && (code_n != tgt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q <= RESET_CODE;
            go_q   <= 1'b0;
        end else begin
            code_q <= code_n;
            go_q   <= go_n;
        end
    end

    assign code     = code_q;
    assign busy     = go_q;
    assign level_mv = code_to_mv(code_q);
endmodule

// File: rtl/vslew_seq_chk.sv
module vslew_seq_chk
    import vslew_pkg::*;
(
    input logic   clk,
    input logic   rst,
    input vcode_t code,
    input vcode_t tgt,
    input logic   go,
    input logic   start,
    input logic   tick,
    input vrate_t rate
);
    // R5: paced steps move the code by at most one
    p_single_step_r5: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(rate) != RATE_JUMP) |->
        (code == $past(code) || code == vcode_t'($past(code) + 1'b1)
                             || code == vcode_t'($past(code) - 1'b1)));

    // R6: no tick, no paced step
    p_tick_gates_r6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(tick) && $past(rate) != RATE_JUMP) |-> $stable(code));

    // R8: busy falls only with the code on the target
    p_done_on_target_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $fell(go)) |-> (code == $past(tgt)));

    // R3: a start toward a different code raises busy
    p_start_raises_r3: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(start) && !$past(go) && $past(tgt) != $past(code)) |-> go);

    // R10: idle without start keeps the code
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(go) && !$past(start)) |-> ($stable(code) && !go));
endmodule

bind vslew_seq vslew_seq_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .code  (code_q),
    .tgt   (tgt),
    .go    (go_q),
    .start (start),
    .tick  (tick),
    .rate  (rate)
);

// File: tb/test_vslew_seq.sv
module test_vslew_seq;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [5:0]  tgt_lo = 6'd16, tgt_hi = 6'd8;
    logic        sel = 1'b0, wr_stb = 1'b0, tick = 1'b1;
    logic [2:0]  rate = 3'd6;
    logic [5:0]  code;
    logic [11:0] level_mv;
    logic        busy;
    int          n_chk = 0, n_bad = 0;
    bit          done = 0;

    always #4 clk = ~clk;

    vslew_seq i_vslew_seq (
        .clk(clk), .rst(rst), .tgt_lo(tgt_lo), .tgt_hi(tgt_hi), .sel(sel),
        .rate(rate), .wr_stb(wr_stb), .tick(tick),
        .code(code), .level_mv(level_mv), .busy(busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int mv_of(input int c);
        if (c < 32) return 800 + 25 * c;
        if (c < 61) return 1600 + 50 * (c - 32);
        return 3100 + 100 * (c - 61);
    endfunction

    function automatic int cycles_for(input int from, input int to, input int r);
        int tot = 0;
        int lo  = (from < to) ? from : to;
        int hi  = (from < to) ? to : from;
        for (int k = lo; k < hi; k++)
            tot += ((k <= 31) ? 1 : (k <= 59) ? 2 : 4) << (6 - r);
        return tot;
    endfunction

    // Strobe toward the low target and follow the ramp until busy falls.
    task automatic ramp_lo(input string req, input int to, input int r);
        int from = code, n = 0, prev, jumps = 0;
        rate = 3'(r); tgt_lo = 6'(to); wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
        check(busy == 1'b1, {req, " R3 busy after strobe"}, busy, 1);
        prev = code;
        while (busy && n < 2000) begin
            @(negedge clk); n++;
            if (code != prev && code != prev + 1 && code != prev - 1) jumps++;
            prev = code;
        end
        check(jumps == 0, {req, " R5 unit steps"}, jumps, 0);
        check(n == cycles_for(from, to, r), {req, " R6 ramp cycles"}, n, cycles_for(from, to, r));
        check(code == to, {req, " R8 final code"}, code, to);
        check(level_mv == 12'(mv_of(to)), {req, " R11 millivolts"}, level_mv, mv_of(to));
    endtask

    task automatic t_reset;
        check(code == 6'd16, "R1 reset code", code, 16);
        check(busy == 1'b0, "R1 reset busy", busy, 0);
        check(level_mv == 12'd1200, "R1 reset mv", level_mv, 1200);
    endtask

    task automatic t_immediate;
        rate = 3'd7; tgt_lo = 6'd0; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
        check(busy == 1'b1 && code == 6'd63, "R7 busy before jump", code, 63);
        @(negedge clk);
        check(code == 6'd0, "R7 jump code", code, 0);
        check(busy == 1'b0, "R7 busy cleared", busy, 0);
        check(level_mv == 12'd800, "R11 code0 mv", level_mv, 800);
    endtask

    task automatic t_equal;
        rate = 3'd6; tgt_lo = code; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
        check(busy == 1'b0, "R3 equal target no busy", busy, 0);
        check(code == 6'd0, "R3 equal target code held", code, 0);
    endtask

    task automatic t_sel_edge;
        int n = 0;
        tgt_hi = 6'd8; rate = 3'd6; sel = 1'b1;
        @(negedge clk);
        check(busy == 1'b1, "R4 sel rise starts", busy, 1);
        while (busy && n < 100) begin @(negedge clk); n++; end
        check(n == 8 && code == 6'd8, "R2 R4 ramp to high target", code, 8);
        sel = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R4 sel fall starts", busy, 1);
        n = 0;
        while (busy && n < 100) begin @(negedge clk); n++; end
        check(code == 6'd0 && n == 8, "R2 back to low target", code, 0);
    endtask

    task automatic t_idle_ignore;
        tgt_hi = 6'd40; tgt_lo = 6'd30;
        repeat (5) @(negedge clk);
        check(code == 6'd0, "R10 idle target change ignored", code, 0);
        check(busy == 1'b0, "R10 idle busy low", busy, 0);
    endtask

    task automatic t_no_tick;
        tick = 1'b0; rate = 3'd6; tgt_lo = 6'd4; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
        repeat (10) @(negedge clk);
        check(code == 6'd0, "R6 no tick no step", code, 0);
        check(busy == 1'b1, "R6 busy held without tick", busy, 1);
        tick = 1'b1;
        repeat (4) @(negedge clk);
        check(code == 6'd4 && busy == 1'b0, "R6 resumes on tick", code, 4);
    endtask

    task automatic t_redirect;
        int n = 0, prev, jumps = 0;
        rate = 3'd6; tgt_lo = 6'd14; wr_stb = 1'b1;
        @(negedge clk); wr_stb = 1'b0;
        repeat (3) @(negedge clk);
        check(code == 6'd7, "R9 mid ramp code", code, 7);
        tgt_lo = 6'd4;
        prev = code;
        while (busy && n < 100) begin
            @(negedge clk); n++;
            if (code != prev + 1 && code != prev - 1 && code != prev) jumps++;
            prev = code;
        end
        check(jumps == 0 && code == 6'd4, "R9 redirect final", code, 4);
        check(n == 3, "R9 redirect cycles", n, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset;
        rst = 1'b0;
        @(negedge clk);
        t_reset;
        ramp_lo("up r6", 20, 6);
        ramp_lo("down r5", 14, 5);
        ramp_lo("cross r6", 34, 6);
        ramp_lo("top r6", 63, 6);
        t_immediate;
        t_equal;
        t_sel_edge;
        t_idle_ignore;
        t_no_tick;
        t_redirect;
        ramp_lo("slow r0", 5, 0);
        ramp_lo("wide r4", 33, 4);
        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (100000) @(posedge clk);
                n_chk++; n_bad++;
                $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            end
        join_any
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule